// File: doc/BRIEF.md
# Slack-Based Supply Level Controller

Once per decoded frame this block chooses whether the supply of an iterative decoder should be stepped up, stepped down or left alone. It also holds the current supply level index. The block looks at four figures for the frame that has just ended:

- whether every parity check passed in the last iteration;
- how many iterations ran (8 bits);
- how long the decoding took (decode-duration timer);
- how much time is left before the next hard deadline (slack timer).

Decoder convergence and the iteration limit are tested first. Only after that is the slack compared with the time that a single iteration took.

The decision is taken on a one-cycle frame-done strobe. The result comes out as a one-cycle pulse on exactly one of three command outputs. The same clock edge moves a saturating 4-bit level index. The index maps linearly onto the supply range: level k stands for 400 + 50·k mV. Level 0 is therefore 0.4 V and level 14 is 1.1 V. A regulator downstream turns the index into a voltage.

Top module: `slack_vctl`

## Requirements
- R1: During reset and in the first cycle after it, the level index is 14 (1.1 V) and all three command outputs are low.
- R2: On a frame-done strobe with the syndrome flag low (checks failing) and an iteration count below 11, the next cycle carries a step_up pulse. The level rises by one, but it holds at 14 if it is already there.
- R3: On a strobe with the syndrome flag high (all checks pass), step_up is never issued. The outcome is step_down if the decrease test passes and step_hold if it does not.
- R4: On a strobe with the syndrome flag low and an iteration count of 11 or more, the decrease test decides between step_down and step_hold.
- R5: The decrease test passes when the slack value is strictly greater than floor(duration / iteration count). With an iteration count of 0 it always fails.
- R6: step_down lowers the level by one, but it holds at 0 if it is already there.
- R7: Each strobe produces exactly one command pulse, in the cycle after the strobe, lasting one cycle. Without a strobe no pulse appears and the level does not change.
- R8: The level index always stays within 0..14 and encodes 400 + 50·level mV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: the frame figures are valid |
| syn_zero | input | 1 | High when all parity checks passed in the last iteration |
| iter_count | input | 8 | Iterations run on the frame |
| dur_time | input | TIME_W | Decode-duration timer value |
| slack_time | input | TIME_W | Time left until the next deadline |
| step_up | output | 1 | One-cycle raise command |
| step_down | output | 1 | One-cycle lower command |
| step_hold | output | 1 | One-cycle keep command |
| level | output | 4 | Current supply level index |

## Verification
The assertions assume that frame_done is a single-cycle strobe and that the four frame figures are stable in the cycle where it is high. They also assume the strobe is never raised in two consecutive cycles, so that each pulse can be tied to one strobe. The bench drives every strobe for exactly one cycle and leaves at least two idle cycles between frames. It changes the figures only at falling edges. The stimulus sweeps the syndrome flag together with iteration counts around the limit of 11, counts of zero and the maximum count, and slack values just below, at and above the per-iteration time. A run of frames forcing many decreases, followed by a run forcing many increases, drives the level into both saturation ends.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

    localparam int LVL_W     = 4;
    localparam int ITER_W    = 8;
    localparam int MV_BASE   = 400;
    localparam int MV_STEP   = 50;

    localparam logic [LVL_W-1:0]  LVL_TOP    = 4'd14;
    localparam logic [LVL_W-1:0]  LVL_BOTTOM = 4'd0;
    localparam logic [ITER_W-1:0] ITER_LIMIT = 8'd11;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_UP   = 2'd1,
        CMD_DOWN = 2'd2
    } vcmd_e;

    typedef struct packed {
        logic              syn_zero;
        logic [ITER_W-1:0] iters;
    } conv_t;

    function automatic logic [LVL_W-1:0] lvl_next(input logic [LVL_W-1:0] cur,
                                                  input vcmd_e cmd);
        logic [LVL_W-1:0] nxt;
        nxt = cur;
        if (cmd == CMD_UP && cur != LVL_TOP)
            nxt = cur + 1'b1;
        else if (cmd == CMD_DOWN && cur != LVL_BOTTOM)
            nxt = cur - 1'b1;
        return nxt;
    endfunction

    function automatic int lvl_to_mv(input logic [LVL_W-1:0] lvl);
        return MV_BASE + MV_STEP * int'(lvl);
    endfunction

endpackage

// File: rtl/vctl_slack_cmp.sv
module vctl_slack_cmp
    import vscale_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic [ITER_W-1:0] iters,
    input  logic [TIME_W-1:0] dur,
    input  logic [TIME_W-1:0] slack,
    output logic              room
);
    localparam int PROD_W = TIME_W + ITER_W;

    logic [PROD_W-1:0] slack_x_iter;
    logic [PROD_W-1:0] dur_ext;

    // slack > floor(dur/iters)  <=>  slack*iters > dur, for iters > 0
    always_comb begin
        slack_x_iter = {{ITER_W{1'b0}}, slack} * {{TIME_W{1'b0}}, iters};
        dur_ext      = {{ITER_W{1'b0}}, dur};
        room         = (iters != '0) && (slack_x_iter > dur_ext);
    end

endmodule

// File: rtl/vctl_decide.sv
module vctl_decide
    import vscale_pkg::*;
(
    input  conv_t conv,
    input  logic  room,
    output vcmd_e cmd
);
    always_comb begin
        if (!conv.syn_zero && conv.iters < ITER_LIMIT)
            cmd = CMD_UP;
        else if (room)
            cmd = CMD_DOWN;
        else
            cmd = CMD_HOLD;
    end

endmodule

// File: rtl/vctl_level.sv
module vctl_level
    import vscale_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  vcmd_e            cmd,
    output logic [LVL_W-1:0] lvl
);
    always_ff @(posedge clk) begin
        if (rst)
            lvl <= LVL_TOP;
        else if (en)
            lvl <= lvl_next(lvl, cmd);
    end

    p_level_range_r8: assert property (@(posedge clk) disable iff (rst)
        lvl <= LVL_TOP);

    p_idle_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(lvl));

endmodule

// File: rtl/slack_vctl.sv
module slack_vctl
    import vscale_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic              syn_zero,
    input  logic [7:0]        iter_count,
    input  logic [TIME_W-1:0] dur_time,
    input  logic [TIME_W-1:0] slack_time,
    output logic              step_up,
    output logic              step_down,
    output logic              step_hold,
    output logic [3:0]        level
);
    conv_t conv;
    logic  room;
    vcmd_e cmd;

    assign conv.syn_zero = syn_zero;
    assign conv.iters    = iter_count;

    vctl_slack_cmp #(.TIME_W(TIME_W)) u_cmp (
        .iters (iter_count),
        .dur   (dur_time),
        .slack (slack_time),
        .room  (room)
    );

    vctl_decide u_dec (
        .conv (conv),
        .room (room),
        .cmd  (cmd)
    );

    vctl_level u_lvl (
        .clk (clk),
        .rst (rst),
        .en  (frame_done),
        .cmd (cmd),
        .lvl (level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step_up   <= 1'b0;
            step_down <= 1'b0;
            step_hold <= 1'b0;
        end else begin
            step_up   <= frame_done && (cmd == CMD_UP);
            step_down <= frame_done && (cmd == CMD_DOWN);
            step_hold <= frame_done && (cmd == CMD_HOLD);
        end
    end

    p_one_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_down, step_hold}));

    p_pulse_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (step_up || step_down || step_hold));

    p_no_up_on_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_done && syn_zero) |=> !step_up);

    p_up_below_limit_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !syn_zero && iter_count < ITER_LIMIT) |=> step_up);

    p_zero_iter_no_down_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_done && iter_count == 8'd0) |=> !step_down);

    p_up_moves_level_r2: assert property (@(posedge clk) disable iff (rst)
        step_up |-> (level == $past(level) + 4'd1) ||
                    (level == LVL_TOP && $past(level) == LVL_TOP));

    p_down_moves_level_r6: assert property (@(posedge clk) disable iff (rst)
        step_down |-> (level == $past(level) - 4'd1) ||
                      (level == LVL_BOTTOM && $past(level) == LVL_BOTTOM));

endmodule

// File: tb/tb_slack_vctl.sv
module tb_slack_vctl;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_done;
    logic          syn_zero;
    logic [7:0]    iter_count;
    logic [TW-1:0] dur_time;
    logic [TW-1:0] slack_time;
    logic          step_up, step_down, step_hold;
    logic [3:0]    level;

    int checks   = 0;
    int failures = 0;
    int exp_lvl  = 14;
    bit done_flag = 0;

    always #5 clk = ~clk;

    slack_vctl #(.TIME_W(TW)) dut (
        .clk(clk), .rst(rst), .frame_done(frame_done), .syn_zero(syn_zero),
        .iter_count(iter_count), .dur_time(dur_time), .slack_time(slack_time),
        .step_up(step_up), .step_down(step_down), .step_hold(step_hold),
        .level(level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iter_pick(input int i);
        case (i)
            0: return 0;   1: return 1;   2: return 5;   3: return 10;
            4: return 11;  5: return 12;  default: return 255;
        endcase
    endfunction

    function automatic int dur_pick(input int i);
        case (i)
            0: return 0; 1: return 7; 2: return 40; default: return 200;
        endcase
    endfunction

    function automatic int slack_pick(input int i);
        case (i)
            0: return 0; 1: return 3; 2: return 4; 3: return 5; default: return 100;
        endcase
    endfunction

    // cmd: 1 up, 2 down, 0 hold
    task automatic frame(input bit sz, input int it, input int du, input int sl);
        int  ecmd;
        int  prev;
        string tag;
        ecmd = 0;
        if (!sz && it < 11) ecmd = 1;
        else if (it != 0 && sl > du / it) ecmd = 2;
        tag = (ecmd == 1) ? "R2" : (it == 0 ? "R5" : (sz ? "R3" : "R4"));
        @(negedge clk);
        syn_zero = sz; iter_count = 8'(it); dur_time = TW'(du); slack_time = TW'(sl);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        prev = exp_lvl;
        if (ecmd == 1 && exp_lvl < 14) exp_lvl++;
        if (ecmd == 2 && exp_lvl > 0)  exp_lvl--;
        check({step_up, step_down, step_hold} ==
              (ecmd == 1 ? 3'b100 : ecmd == 2 ? 3'b010 : 3'b001),
              tag, int'({step_up, step_down, step_hold}),
              ecmd == 1 ? 4 : ecmd == 2 ? 2 : 1);
        check(int'(level) == exp_lvl,
              (ecmd == 2 && prev == 0) ? "R6" : tag, int'(level), exp_lvl);
        @(negedge clk);
        check({step_up, step_down, step_hold} == 3'b000 && int'(level) == exp_lvl,
              "R7", int'({step_up, step_down, step_hold, level}), exp_lvl);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_done = 1'b0; syn_zero = 1'b0;
        iter_count = '0; dur_time = '0; slack_time = '0;
        repeat (3) @(negedge clk);
        check(level == 4'd14 && {step_up, step_down, step_hold} == 3'b000,
              "R1", int'(level), 14);
        rst = 1'b0;
        @(negedge clk);
        check(level == 4'd14 && {step_up, step_down, step_hold} == 3'b000,
              "R1", int'(level), 14);
        // R8: top index encodes 1100 mV
        check(vscale_pkg::lvl_to_mv(level) == 1100, "R8",
              vscale_pkg::lvl_to_mv(level), 1100);

        // R3/R6: drive to floor with passing frames and ample slack
        for (int k = 0; k < 18; k++) frame(1'b1, 4, 40, 100);
        check(level == 4'd0 && vscale_pkg::lvl_to_mv(level) == 400, "R6", int'(level), 0);
        // R2: climb back to top, then saturate
        for (int k = 0; k < 17; k++) frame(1'b0, 3, 40, 100);
        check(level == 4'd14, "R2", int'(level), 14);
        for (int k = 0; k < 8; k++) frame(1'b1, 8, 40, 100);

        // sweep all combinations
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 7; i++)
                for (int d = 0; d < 4; d++)
                    for (int l = 0; l < 5; l++)
                        frame(s[0], iter_pick(i), dur_pick(d), slack_pick(l));

        // R7: idle cycles leave everything quiet
        repeat (4) begin
            @(negedge clk);
            check({step_up, step_down, step_hold} == 3'b000 && int'(level) == exp_lvl,
                  "R7", int'(level), exp_lvl);
        end
        check(level <= 4'd14, "R8", int'(level), 14);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule